// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Array

This block is a small translation buffer for 4 KiB pages. A request gives a 32-bit virtual address, the current privilege ring and the kind of access: instruction fetch, data load or data store. One clock later the block reports one of three outcomes. A single live entry may match, and the block then returns the physical address. No entry may match, which is a miss. Two or more entries may match, which is a multi-hit fault. A single match can still carry a permission fault, for the ring or for write or execute rights.

Every entry carries an 8-bit address-space tag. The tag is taken from a ring-to-tag register at the moment the entry is written. An entry matches only if its tag equals one of the four ring bytes in that register, and the position of that byte gives the entry's ring. Tag 0 is reserved for empty entries. The entries sit in three groups. The first is an auto-refilled set-associative region that uses per-set round-robin victim choice. The second is a few pinned single-entry ways that software writes directly. The third is a wired way of eight 512 MiB entries. At reset the wired way maps the whole address space one-to-one for ring 0.

Software uses a command port to write, invalidate or refill entries, and a separate port to load the ring-to-tag register. The page-table walker and the cache sit outside this block.

Top module: `asid_tlb`

## Requirements
- R1: Each cycle with `lk_valid` high gives `res_valid` high on the next cycle, with exactly one of `res_hit`, `res_miss` and `res_multi` set. The outputs are low when no lookup was made.
- R2: A hit with no fault returns `res_paddr` as the entry's physical page joined to the untranslated low bits. For a 4 KiB entry those are bits 11:0. For a wired 512 MiB entry, bits 31:29 come from the entry and bits 28:0 come from the virtual address.
- R3: `rasid_q` holds the tag for ring n in byte n, and resets to 32'h04030201. A write through `rasid_we` replaces bytes 3..1, and byte 0 stays 8'h01.
- R4: A command writes the tag `rasid_q` byte `cmd_ring` into the entry. A lookup matches an entry only if the entry's tag equals some byte of `rasid_q`, so changing that byte hides the entry.
- R5: An entry with tag 0 never matches. An invalidate command (cmd 2) sets the addressed entry's tag to 0.
- R6: When two or more live entries match, `res_multi` is set, `res_hit` is clear and `res_paddr` is 0.
- R7: A single match raises `res_perm` together with `res_hit`, and drives `res_paddr` to 0, in any of three cases. The entry's ring may be lower than `lk_ring`. A store (`lk_acc` 2) may hit an entry without write rights. A fetch (`lk_acc` 0) may hit an entry without execute rights. A load (`lk_acc` 1) is checked only against the ring.
- R8: After reset, the wired way holds entry i mapping virtual bits 31:29 = i to physical bits 31:29 = i, with tag 1, write and execute rights. Every other entry is empty.
- R9: A refill (cmd 3) writes the auto region set chosen by `cmd_vpn` bits 1:0, into the way named by that set's round-robin pointer, which starts at 0 and then advances by one, wrapping.
- R10: A command takes effect on the next clock edge. A lookup in the same cycle as the command sees the contents from before it.
- R11: Way numbers 0..3 are the auto region, with `cmd_index` selecting the set. Ways 4..6 are pinned, and `cmd_index` is ignored for them. Way 7 is the wired way, with `cmd_index` equal to virtual bits 31:29. Cmd 1 writes the way and index given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_ring | input | 2 | Current privilege ring |
| lk_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| res_valid | output | 1 | Result present |
| res_paddr | output | 32 | Physical address on a clean hit, else 0 |
| res_hit | output | 1 | Exactly one live match |
| res_miss | output | 1 | No live match |
| res_multi | output | 1 | Two or more live matches |
| res_perm | output | 1 | Permission fault on the single match |
| cmd | input | 2 | 0 none, 1 write, 2 invalidate, 3 refill |
| cmd_way | input | 3 | Target way for write and invalidate |
| cmd_index | input | 3 | Set or wired slot for write and invalidate |
| cmd_vpn | input | 20 | Virtual page number to store |
| cmd_ppn | input | 20 | Physical page number to store |
| cmd_ring | input | 2 | Ring whose tag the new entry takes |
| cmd_wen | input | 1 | Write right of the new entry |
| cmd_xen | input | 1 | Execute right of the new entry |
| rasid_we | input | 1 | Load the ring-to-tag register |
| rasid_wdata | input | 32 | New ring-to-tag value |
| rasid_q | output | 32 | Current ring-to-tag value |

## Verification
The hardest state to reach from the ports is a clean single hit in a 4 KiB entry. At reset the wired way already covers every address with tag 1, so any ring-0 entry written on top of it first produces a multi-hit. The bench therefore writes an auto entry, observes the multi-hit, and then invalidates the covering wired slot. It issues that invalidate in the same cycle as a lookup, so the old double match is still seen once before the clean hit appears. The round-robin wrap is reached by five refills into one set after that wired slot is gone, and the oldest page is then shown to miss.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int VA_W  = 32;
  localparam int PG_W  = 12;
  localparam int VPN_W = VA_W - PG_W;
  localparam int TAG_W = 8;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_INVAL  = 2'd2,
    OP_REFILL = 2'd3
  } op_e;

  typedef struct packed {
    logic [TAG_W-1:0] asid;
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
    logic             wen;
    logic             xen;
  } tlb_ent_t;
endpackage

// File: rtl/asid_tlb_rasid.sv
module asid_tlb_rasid
  import asid_tlb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  localparam logic [TAG_W-1:0] KERNEL_TAG = 8'h01;

  always_ff @(posedge clk) begin
    if (rst) q <= 32'h0403_0201;
    else if (we) q <= {wdata[31:8], KERNEL_TAG};
  end

  assert_rasid_load_R3: assert property (@(posedge clk) disable iff (rst)
    we |=> (q[31:8] == $past(wdata[31:8])) && (q[7:0] == KERNEL_TAG));
endmodule

// File: rtl/asid_tlb_rr.sv
module asid_tlb_rr #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SB = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WB = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [SB-1:0] set,
  output logic [WB-1:0] victim
);
  logic [WB-1:0] ptr_q [SETS];

  assign victim = ptr_q[set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      ptr_q[set] <= (victim == WB'(WAYS - 1)) ? '0 : victim + WB'(1);
    end
  end

  assert_rr_step_R9: assert property (@(posedge clk) disable iff (rst)
    adv |=> ptr_q[$past(set)] ==
      (($past(victim) == WB'(WAYS - 1)) ? WB'(0) : $past(victim) + WB'(1)));
endmodule

// File: rtl/asid_tlb_cmp.sv
module asid_tlb_cmp
  import asid_tlb_pkg::*;
#(
  parameter int TAG_BITS = VPN_W
) (
  input  tlb_ent_t        ent,
  input  logic [VA_W-1:0] vaddr,
  input  logic [31:0]     rasid,
  output logic            hit,
  output logic [1:0]      ring,
  output logic [VA_W-1:0] paddr
);
  logic ring_ok;

  always_comb begin
    ring_ok = 1'b0;
    ring    = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      if (ent.asid == rasid[8*k +: 8]) begin
        ring_ok = 1'b1;
        ring    = 2'(k);
      end
    end
    hit   = (ent.asid != '0) && ring_ok &&
            (ent.vpn[VPN_W-1 -: TAG_BITS] == vaddr[VA_W-1 -: TAG_BITS]);
    paddr = {ent.ppn[VPN_W-1 -: TAG_BITS], vaddr[VA_W-TAG_BITS-1:0]};
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int SETS       = 4,
  parameter int AUTO_WAYS  = 4,
  parameter int PIN_WAYS   = 3,
  parameter int WIRED_BITS = 3,
  localparam int SET_BITS = $clog2(SETS),
  localparam int WIRED_N  = 1 << WIRED_BITS,
  localparam int NWAYS    = AUTO_WAYS + PIN_WAYS + 1,
  localparam int WAY_W    = $clog2(NWAYS),
  localparam int IDX_W    = (SET_BITS > WIRED_BITS) ? SET_BITS : WIRED_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic [1:0]       lk_ring,
  input  logic [1:0]       lk_acc,
  output logic             res_valid,
  output logic [31:0]      res_paddr,
  output logic             res_hit,
  output logic             res_miss,
  output logic             res_multi,
  output logic             res_perm,
  input  logic [1:0]       cmd,
  input  logic [WAY_W-1:0] cmd_way,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [19:0]      cmd_vpn,
  input  logic [19:0]      cmd_ppn,
  input  logic [1:0]       cmd_ring,
  input  logic             cmd_wen,
  input  logic             cmd_xen,
  input  logic             rasid_we,
  input  logic [31:0]      rasid_wdata,
  output logic [31:0]      rasid_q
);
  localparam int PIN_BASE   = AUTO_WAYS;
  localparam int WIRED_WAY  = AUTO_WAYS + PIN_WAYS;
  localparam int NCAND      = AUTO_WAYS + PIN_WAYS + WIRED_N;
  localparam int CNT_W      = $clog2(NCAND + 1);
  localparam int VICT_W     = (AUTO_WAYS > 1) ? $clog2(AUTO_WAYS) : 1;

  tlb_ent_t auto_q  [SETS][AUTO_WAYS];
  tlb_ent_t pin_q   [PIN_WAYS];
  tlb_ent_t wired_q [WIRED_N];

  // ring-to-tag register
  asid_tlb_rasid u_rasid (
    .clk(clk), .rst(rst), .we(rasid_we), .wdata(rasid_wdata), .q(rasid_q)
  );

  // refill victim selection
  logic [VICT_W-1:0] victim;
  logic              refill;
  assign refill = (op_e'(cmd) == OP_REFILL);

  asid_tlb_rr #(.SETS(SETS), .WAYS(AUTO_WAYS)) u_rr (
    .clk(clk), .rst(rst), .adv(refill),
    .set(cmd_vpn[SET_BITS-1:0]), .victim(victim)
  );

  // entry image built from command fields
  tlb_ent_t new_ent;
  always_comb begin
    new_ent.asid = rasid_q[8*cmd_ring +: 8];
    new_ent.vpn  = cmd_vpn;
    new_ent.ppn  = cmd_ppn;
    new_ent.wen  = cmd_wen;
    new_ent.xen  = cmd_xen;
  end

  logic do_wr, do_inv;
  assign do_wr  = (op_e'(cmd) == OP_WRITE);
  assign do_inv = (op_e'(cmd) == OP_INVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < AUTO_WAYS; w++) auto_q[s][w] <= '0;
      for (int p = 0; p < PIN_WAYS; p++) pin_q[p] <= '0;
      for (int i = 0; i < WIRED_N; i++) begin
        wired_q[i].asid <= 8'h01;
        wired_q[i].vpn  <= {WIRED_BITS'(i), {(VPN_W-WIRED_BITS){1'b0}}};
        wired_q[i].ppn  <= {WIRED_BITS'(i), {(VPN_W-WIRED_BITS){1'b0}}};
        wired_q[i].wen  <= 1'b1;
        wired_q[i].xen  <= 1'b1;
      end
    end else begin
      for (int w = 0; w < AUTO_WAYS; w++) begin
        if (cmd_way == WAY_W'(w)) begin
          if (do_wr)  auto_q[cmd_index[SET_BITS-1:0]][w] <= new_ent;
          if (do_inv) auto_q[cmd_index[SET_BITS-1:0]][w].asid <= '0;
        end
      end
      for (int p = 0; p < PIN_WAYS; p++) begin
        if (cmd_way == WAY_W'(PIN_BASE + p)) begin
          if (do_wr)  pin_q[p] <= new_ent;
          if (do_inv) pin_q[p].asid <= '0;
        end
      end
      if (cmd_way == WAY_W'(WIRED_WAY)) begin
        if (do_wr)  wired_q[cmd_index[WIRED_BITS-1:0]] <= new_ent;
        if (do_inv) wired_q[cmd_index[WIRED_BITS-1:0]].asid <= '0;
      end
      if (refill) auto_q[cmd_vpn[SET_BITS-1:0]][victim] <= new_ent;
    end
  end

  // parallel compare over the set's ways, pinned ways and wired way
  logic [SET_BITS-1:0] lk_set;
  assign lk_set = lk_vaddr[PG_W +: SET_BITS];

  tlb_ent_t          cand  [NCAND];
  logic [NCAND-1:0]  match;
  logic [1:0]        cring [NCAND];
  logic [VA_W-1:0]   cpa   [NCAND];

  for (genvar g = 0; g < NCAND; g++) begin : g_cand
    if (g < AUTO_WAYS) begin : g_auto
      assign cand[g] = auto_q[lk_set][g];
      asid_tlb_cmp #(.TAG_BITS(VPN_W)) u_cmp (
        .ent(cand[g]), .vaddr(lk_vaddr), .rasid(rasid_q),
        .hit(match[g]), .ring(cring[g]), .paddr(cpa[g]));
    end else if (g < WIRED_WAY) begin : g_pin
      assign cand[g] = pin_q[g - PIN_BASE];
      asid_tlb_cmp #(.TAG_BITS(VPN_W)) u_cmp (
        .ent(cand[g]), .vaddr(lk_vaddr), .rasid(rasid_q),
        .hit(match[g]), .ring(cring[g]), .paddr(cpa[g]));
    end else begin : g_wired
      assign cand[g] = wired_q[g - WIRED_WAY];
      asid_tlb_cmp #(.TAG_BITS(WIRED_BITS)) u_cmp (
        .ent(cand[g]), .vaddr(lk_vaddr), .rasid(rasid_q),
        .hit(match[g]), .ring(cring[g]), .paddr(cpa[g]));
    end
  end

  logic [CNT_W-1:0] n_match;
  logic [VA_W-1:0]  sel_pa;
  logic [1:0]       sel_ring;
  logic             sel_wen, sel_xen, viol;

  always_comb begin
    n_match  = '0;
    sel_pa   = '0;
    sel_ring = '0;
    sel_wen  = 1'b0;
    sel_xen  = 1'b0;
    for (int i = 0; i < NCAND; i++) begin
      n_match = n_match + CNT_W'(match[i]);
      if (match[i]) begin
        sel_pa   = sel_pa   | cpa[i];
        sel_ring = sel_ring | cring[i];
        sel_wen  = sel_wen  | cand[i].wen;
        sel_xen  = sel_xen  | cand[i].xen;
      end
    end
    viol = (sel_ring < lk_ring) ||
           ((acc_e'(lk_acc) == ACC_STORE) && !sel_wen) ||
           ((acc_e'(lk_acc) == ACC_FETCH) && !sel_xen);
  end

  logic one_hit;
  assign one_hit = (n_match == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_paddr <= '0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_multi <= 1'b0;
      res_perm  <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && one_hit;
      res_miss  <= lk_valid && (n_match == '0);
      res_multi <= lk_valid && (n_match > CNT_W'(1));
      res_perm  <= lk_valid && one_hit && viol;
      res_paddr <= (lk_valid && one_hit && !viol) ? sel_pa : '0;
    end
  end

  assert_result_follows_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({res_hit, res_miss, res_multi}) == 1);
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && one_hit && !viol) |=> res_paddr[PG_W-1:0] == $past(lk_vaddr[PG_W-1:0]));
  assert_perm_on_hit_R7: assert property (@(posedge clk) disable iff (rst)
    res_perm |-> (res_hit && res_paddr == '0));
  assert_multi_no_addr_R6: assert property (@(posedge clk) disable iff (rst)
    res_multi |-> (res_paddr == '0 && !res_perm));
endmodule

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_ring, lk_acc;
  logic        res_valid, res_hit, res_miss, res_multi, res_perm;
  logic [31:0] res_paddr;
  logic [1:0]  cmd;
  logic [2:0]  cmd_way, cmd_index;
  logic [19:0] cmd_vpn, cmd_ppn;
  logic [1:0]  cmd_ring;
  logic        cmd_wen, cmd_xen, rasid_we;
  logic [31:0] rasid_wdata, rasid_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_ring(lk_ring), .lk_acc(lk_acc), .res_valid(res_valid),
    .res_paddr(res_paddr), .res_hit(res_hit), .res_miss(res_miss),
    .res_multi(res_multi), .res_perm(res_perm), .cmd(cmd), .cmd_way(cmd_way),
    .cmd_index(cmd_index), .cmd_vpn(cmd_vpn), .cmd_ppn(cmd_ppn),
    .cmd_ring(cmd_ring), .cmd_wen(cmd_wen), .cmd_xen(cmd_xen),
    .rasid_we(rasid_we), .rasid_wdata(rasid_wdata), .rasid_q(rasid_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // result packed as {valid,hit,miss,multi,perm}
  task automatic look(input logic [31:0] va, input logic [1:0] ring,
                      input logic [1:0] acc, output logic [4:0] fl,
                      output logic [31:0] pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_ring = ring; lk_acc = acc;
    @(negedge clk);
    lk_valid = 1'b0;
    fl = {res_valid, res_hit, res_miss, res_multi, res_perm};
    pa = res_paddr;
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] way,
                       input logic [2:0] idx, input logic [19:0] vpn,
                       input logic [19:0] ppn, input logic [1:0] ring,
                       input logic w, input logic x);
    @(negedge clk);
    cmd = op; cmd_way = way; cmd_index = idx; cmd_vpn = vpn;
    cmd_ppn = ppn; cmd_ring = ring; cmd_wen = w; cmd_xen = x;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic load_rasid(input logic [31:0] v);
    @(negedge clk);
    rasid_we = 1'b1; rasid_wdata = v;
    @(negedge clk);
    rasid_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [4:0] fl; logic [31:0] pa;
    chk("R3", "rasid reset", rasid_q, 32'h0403_0201);
    chk("R1", "idle valid", {31'd0, res_valid}, 32'd0);
    look(32'h1234_5678, 2'd0, 2'd1, fl, pa);
    chk("R8", "wired identity flags", {27'd0, fl}, {27'd0, 5'b11000});
    chk("R8", "wired identity addr", pa, 32'h1234_5678);
    look(32'hE000_0ABC, 2'd0, 2'd0, fl, pa);
    chk("R2", "top wired slot fetch", pa, 32'hE000_0ABC);
    @(negedge clk);
    chk("R1", "valid drops after lookup", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_ring_fault;
    logic [4:0] fl; logic [31:0] pa;
    look(32'h1234_5678, 2'd1, 2'd1, fl, pa);
    chk("R7", "ring fault flags", {27'd0, fl}, {27'd0, 5'b11001});
    chk("R7", "ring fault addr", pa, 32'd0);
  endtask

  task automatic t_rasid;
    load_rasid(32'hAABB_CC55);
    chk("R3", "kernel byte fixed", rasid_q, 32'hAABB_CC01);
    load_rasid(32'h0403_0299);
    chk("R3", "restore", rasid_q, 32'h0403_0201);
  endtask

  task automatic t_multi_then_hit;
    logic [4:0] fl; logic [31:0] pa;
    issue(2'd1, 3'd1, 3'd1, 20'h40001, 20'h12345, 2'd0, 1'b1, 1'b0);
    look(32'h4000_1ABC, 2'd0, 2'd1, fl, pa);
    chk("R6", "overlap multi flags", {27'd0, fl}, {27'd0, 5'b10010});
    chk("R6", "overlap multi addr", pa, 32'd0);
    // invalidate wired slot 2 in the same cycle as a lookup
    @(negedge clk);
    cmd = 2'd2; cmd_way = 3'd7; cmd_index = 3'd2;
    lk_valid = 1'b1; lk_vaddr = 32'h4000_1ABC; lk_ring = 2'd0; lk_acc = 2'd1;
    @(negedge clk);
    cmd = 2'd0; lk_valid = 1'b0;
    chk("R10", "same-cycle sees old", {31'd0, res_multi}, 32'd1);
    look(32'h4000_1ABC, 2'd0, 2'd1, fl, pa);
    chk("R11", "auto way hit flags", {27'd0, fl}, {27'd0, 5'b11000});
    chk("R2", "auto 4k address", pa, 32'h1234_5ABC);
    look(32'h4000_1ABC, 2'd0, 2'd2, fl, pa);
    chk("R7", "store with write right", {27'd0, fl}, {27'd0, 5'b11000});
    look(32'h4000_1ABC, 2'd0, 2'd0, fl, pa);
    chk("R7", "fetch without execute", {27'd0, fl}, {27'd0, 5'b11001});
  endtask

  task automatic t_pinned_tag;
    logic [4:0] fl; logic [31:0] pa;
    issue(2'd1, 3'd4, 3'd5, 20'h40002, 20'h0ABCD, 2'd3, 1'b0, 1'b0);
    look(32'h4000_2010, 2'd3, 2'd1, fl, pa);
    chk("R11", "pinned way hit", {27'd0, fl}, {27'd0, 5'b11000});
    chk("R4", "pinned ring3 addr", pa, 32'h0ABC_D010);
    load_rasid(32'h0703_0201);
    look(32'h4000_2010, 2'd3, 2'd1, fl, pa);
    chk("R4", "tag no longer current", {27'd0, fl}, {27'd0, 5'b10100});
  endtask

  task automatic t_invalidate;
    logic [4:0] fl; logic [31:0] pa;
    issue(2'd2, 3'd1, 3'd1, 20'h0, 20'h0, 2'd0, 1'b0, 1'b0);
    look(32'h4000_1ABC, 2'd0, 2'd1, fl, pa);
    chk("R5", "invalidated entry misses", {27'd0, fl}, {27'd0, 5'b10100});
  endtask

  task automatic t_refill;
    logic [4:0] fl; logic [31:0] pa;
    for (int k = 0; k < 5; k++)
      issue(2'd3, 3'd0, 3'd0, 20'h40010 + 20'(4*k), 20'h50000 + 20'(k),
            2'd0, 1'b1, 1'b1);
    look(32'h4001_4000, 2'd0, 2'd0, fl, pa);
    chk("R9", "second refill kept", pa, 32'h5000_1000);
    look(32'h4001_0000, 2'd0, 2'd1, fl, pa);
    chk("R9", "oldest refill evicted", {27'd0, fl}, {27'd0, 5'b10100});
    look(32'h4002_0000, 2'd0, 2'd2, fl, pa);
    chk("R9", "wrapped refill present", pa, 32'h5000_4000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; lk_valid = 1'b0; lk_vaddr = '0; lk_ring = '0; lk_acc = '0;
    cmd = '0; cmd_way = '0; cmd_index = '0; cmd_vpn = '0; cmd_ppn = '0;
    cmd_ring = '0; cmd_wen = 1'b0; cmd_xen = 1'b0;
    rasid_we = 1'b0; rasid_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ring_fault();
    t_rasid();
    t_multi_then_hit();
    t_pinned_tag();
    t_invalidate();
    t_refill();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule